// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This controller steps through a multi-register load or store. It is started with a base address, a 16-bit register list and direction and timing flags. It then walks the list from the lowest-numbered register up. On each cycle it issues one 32-bit word access to the memory system and names the register that the external register file should supply or receive. Addresses always ascend in steps of 4. The first address is computed from the base, the number of set list bits and the selected addressing mode.

Alongside the accesses, the sequencer produces the side signals that an instruction of this kind needs:

- a base writeback value and strobe;
- a sequential or nonsequential marking for each access;
- a user-bank select that substitutes user-mode registers;
- a request to copy the saved status word into the current status word;
- an internal idle cycle after loads;
- a hint that the next instruction fetch after a store is nonsequential.

A busy/done handshake brackets each operation.

Top module: `blkx_seq`

## Requirements
- R1: An accepted operation issues exactly as many accesses as `list_i` has set bits, on consecutive cycles, lowest register index first. `reg_idx_o` gives the index, and `mem_we_o` is high for a store (`load_i`=0) and low for a load.
- R2: The first access address depends on `up_i` and `pre_i`. With `up_i`=1 and `pre_i`=0 it is base. With `up_i`=1 and `pre_i`=1 it is base+4. With `up_i`=0 and `pre_i`=1 it is base−4·n. With `up_i`=0 and `pre_i`=0 it is base−4·n+4. Here n is the popcount of the list, and arithmetic is modulo 2^32.
- R3: Each access after the first is at the previous address plus 4.
- R4: `mem_seq_o` is 0 on the first access of an operation and 1 on every later one.
- R5: The writeback value is base+4·n when `up_i`=1 and base−4·n when `up_i`=0. It is driven only when `wb_i`=1.
- R6: For a load with `wb_i`=1, `wb_en_o` pulses for one cycle immediately before the first access and never together with an access, so a later load of the base register overrides it.
- R7: For a store, the cycle after the last access asserts `fetch_nseq_o`, plus `wb_en_o` when `wb_i`=1.
- R8: `user_bank_o` is high on every access when `special_i`=1 and either the operation is a store or list bit 15 is clear. Otherwise it stays low.
- R9: `psr_restore_o` is high in the load idle cycle only when `special_i`=1, `load_i`=1, list bit 15 is set, and `mode_i` is neither 5'b10000 (user) nor 5'b11111 (system).
- R10: For a load, `idle_o` is high for exactly the one cycle following the last access.
- R11: An empty list produces no access, no writeback and no idle cycle, and `done_o` is high in the cycle after acceptance.
- R12: `start_i` is accepted only while `busy_o` is low. `busy_o` stays high from the cycle after acceptance through the single `done_o` cycle. Inputs that change while busy have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| base_i | input | 32 | Base register value |
| list_i | input | 16 | Register list, bit k selects register k |
| load_i | input | 1 | 1 load, 0 store |
| up_i | input | 1 | 1 ascending base, 0 descending base |
| pre_i | input | 1 | 1 adjust before access, 0 after |
| wb_i | input | 1 | Base writeback enable |
| special_i | input | 1 | User-bank / status-restore qualifier |
| mode_i | input | 5 | Current processor mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of an operation |
| mem_req_o | output | 1 | Word access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Access address |
| mem_seq_o | output | 1 | Access is sequential |
| reg_idx_o | output | 4 | Register transferred by this access |
| user_bank_o | output | 1 | Use user-mode register bank |
| wb_en_o | output | 1 | Write base register |
| wb_val_o | output | 32 | Base writeback value |
| idle_o | output | 1 | Internal idle cycle after a load |
| psr_restore_o | output | 1 | Copy saved status into current status |
| fetch_nseq_o | output | 1 | Next fetch is nonsequential |

## Verification
The bench builds the block with its default 16-entry list and 32-bit addresses. This brings the register-15 cases within reach: both the status-restore path and the user-bank exclusion depend on the top list bit. It also reaches full-list operations, single-entry lists and decrementing modes that wrap below address zero. Random lists, bases, directions and modes are mixed with directed empty-list, user-mode and system-mode cases. One operation changes every input while busy to show that the latched values drive the sequence.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDWB,
    ST_XFER,
    ST_LDIDLE,
    ST_STEND,
    ST_FIN
  } blkx_state_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_SYS = 5'b11111;
endpackage

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc #(
  parameter int NREG  = 16,
  parameter int AW    = 32,
  parameter int BYTES = 4,
  localparam int CW   = $clog2(NREG + 1)
) (
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] list_i,
  input  logic            up_i,
  input  logic            pre_i,
  output logic [CW-1:0]   count_o,
  output logic [AW-1:0]   first_o,
  output logic [AW-1:0]   wb_o
);
  localparam logic [AW-1:0] STEP = AW'(BYTES);

  logic [AW-1:0] span;

  always_comb begin
    count_o = '0;
    for (int k = 0; k < NREG; k++) count_o = count_o + CW'(list_i[k]);
  end

  assign span = AW'(count_o) * STEP;

  always_comb begin
    unique case ({up_i, pre_i})
      2'b10:   first_o = base_i;
      2'b11:   first_o = base_i + STEP;
      2'b01:   first_o = base_i - span;
      default: first_o = base_i - span + STEP;
    endcase
  end

  assign wb_o = up_i ? base_i + span : base_i - span;
endmodule

// File: rtl/blkx_pick.sv
module blkx_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec_i,
  output logic [IW-1:0]   idx_o,
  output logic [NREG-1:0] rest_o,
  output logic            last_o
);
  // one-hot of the lowest set bit, built per position
  logic [NREG-1:0] low_oh;
  logic [NREG-1:0] below;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NREG; g++) begin : g_below
      assign below[g] = below[g-1] | vec_i[g-1];
    end
    for (g = 0; g < NREG; g++) begin : g_oh
      assign low_oh[g] = vec_i[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NREG; k++) if (low_oh[k]) idx_o = IW'(k);
  end

  assign rest_o = vec_i & ~low_oh;
  assign last_o = (rest_o == '0);
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int AW    = 32,
  parameter int BYTES = 4,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] list_i,
  input  logic            load_i,
  input  logic            up_i,
  input  logic            pre_i,
  input  logic            wb_i,
  input  logic            special_i,
  input  logic [4:0]      mode_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_seq_o,
  output logic [IW-1:0]   reg_idx_o,
  output logic            user_bank_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o,
  output logic            idle_o,
  output logic            psr_restore_o,
  output logic            fetch_nseq_o
);
  localparam logic [AW-1:0] STEP = AW'(BYTES);
  localparam int TOP = NREG - 1;

  blkx_state_e     state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, wbv_q;
  logic            load_q, wb_q, ubank_q, rest_q, first_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr, wb_addr;
  logic [IW-1:0]   pick_idx;
  logic [NREG-1:0] pick_rest;
  logic            pick_last;
  logic            priv_mode;

  blkx_addr_calc #(.NREG(NREG), .AW(AW), .BYTES(BYTES)) u_addr (
    .base_i (base_i),
    .list_i (list_i),
    .up_i   (up_i),
    .pre_i  (pre_i),
    .count_o(cnt),
    .first_o(first_addr),
    .wb_o   (wb_addr)
  );

  blkx_pick #(.NREG(NREG)) u_pick (
    .vec_i (rem_q),
    .idx_o (pick_idx),
    .rest_o(pick_rest),
    .last_o(pick_last)
  );

  assign priv_mode = (mode_i != MODE_USR) && (mode_i != MODE_SYS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      ubank_q <= 1'b0;
      rest_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          load_q  <= load_i;
          wb_q    <= wb_i;
          ubank_q <= special_i & (~load_i | ~list_i[TOP]);
          rest_q  <= special_i & load_i & list_i[TOP] & priv_mode;
          rem_q   <= list_i;
          addr_q  <= first_addr;
          wbv_q   <= wb_addr;
          first_q <= 1'b1;
          if (cnt == '0)          state_q <= ST_FIN;
          else if (load_i & wb_i) state_q <= ST_LDWB;
          else                    state_q <= ST_XFER;
        end
        ST_LDWB: state_q <= ST_XFER;
        ST_XFER: begin
          rem_q   <= pick_rest;
          addr_q  <= addr_q + STEP;
          first_q <= 1'b0;
          if (pick_last) state_q <= load_q ? ST_LDIDLE : ST_STEND;
        end
        ST_LDIDLE: state_q <= ST_FIN;
        ST_STEND:  state_q <= ST_FIN;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FIN);
  assign mem_req_o     = (state_q == ST_XFER);
  assign mem_we_o      = mem_req_o & ~load_q;
  assign mem_addr_o    = addr_q;
  assign mem_seq_o     = mem_req_o & ~first_q;
  assign reg_idx_o     = pick_idx;
  assign user_bank_o   = mem_req_o & ubank_q;
  assign wb_en_o       = (state_q == ST_LDWB) | ((state_q == ST_STEND) & wb_q);
  assign wb_val_o      = wbv_q;
  assign idle_o        = (state_q == ST_LDIDLE);
  assign psr_restore_o = idle_o & rest_q;
  assign fetch_nseq_o  = (state_q == ST_STEND);
endmodule

// File: rtl/blkx_seq_chk.sv
module blkx_seq_chk #(
  parameter int AW    = 32,
  parameter int BYTES = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_seq_o,
  input logic          user_bank_o,
  input logic          wb_en_o,
  input logic          idle_o,
  input logic          psr_restore_o
);
  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_addr_o == $past(mem_addr_o) + AW'(BYTES));
  // R4
  first_nseq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_seq_o);
  // R4
  later_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $past(mem_req_o) |-> mem_seq_o);
  // R6
  wb_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> !mem_req_o && !idle_o);
  // R8
  ubank_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_bank_o |-> mem_req_o);
  // R9
  restore_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_restore_o |-> idle_o);
  // R10
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) && !$past(mem_we_o) |-> idle_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R12
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !wb_en_o && !idle_o && !done_o);
endmodule

bind blkx_seq blkx_seq_chk #(.AW(AW), .BYTES(BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_seq_o    (mem_seq_o),
  .user_bank_o  (user_bank_o),
  .wb_en_o      (wb_en_o),
  .idle_o       (idle_o),
  .psr_restore_o(psr_restore_o)
);

// File: tb/blkx_seq_bench.sv
module blkx_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] list_i = '0;
  logic        load_i = 1'b0, up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, special_i = 1'b0;
  logic [4:0]  mode_i = 5'h13;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_seq_o, user_bank_o;
  logic        wb_en_o, idle_o, psr_restore_o, fetch_nseq_o;
  logic [31:0] mem_addr_o, wb_val_o;
  logic [3:0]  reg_idx_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  blkx_seq u_blkx_seq (
    .clk_i, .rst_ni, .start_i, .base_i, .list_i, .load_i, .up_i, .pre_i, .wb_i,
    .special_i, .mode_i, .busy_o, .done_o, .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_seq_o, .reg_idx_o, .user_bank_o, .wb_en_o, .wb_val_o, .idle_o,
    .psr_restore_o, .fetch_nseq_o
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_first(logic [31:0] b, int n, bit up, bit pre);
    case ({up, pre})
      2'b10:   return b;
      2'b11:   return b + 32'd4;
      2'b01:   return b - 32'(4 * n);
      default: return b - 32'(4 * n) + 32'd4;
    endcase
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [15:0] l, input bit ld, input bit up,
                        input bit pre, input bit wb, input bit spc, input logic [4:0] md,
                        input bit scramble);
    int n = $countones(l);
    logic [31:0] a = exp_first(b, n, up, pre);
    logic [31:0] wv = up ? b + 32'(4 * n) : b - 32'(4 * n);
    bit ub = spc && (!ld || !l[15]);
    bit rs = spc && ld && l[15] && md != 5'b10000 && md != 5'b11111;
    bit first = 1'b1;
    @(negedge clk_i);
    base_i = b; list_i = l; load_i = ld; up_i = up; pre_i = pre; wb_i = wb;
    special_i = spc; mode_i = md; start_i = 1'b1;
    @(negedge clk_i);
    if (scramble) begin
      base_i = ~b; list_i = ~l; load_i = !ld; up_i = !up; pre_i = !pre; wb_i = !wb;
      special_i = !spc; mode_i = ~md;
    end else start_i = 1'b0;
    if (n == 0) begin
      chk("R11 done", 32'(done_o), 1);
      chk("R11 noacc", 32'(mem_req_o | wb_en_o | idle_o), 0);
    end else begin
      chk("R12 busy", 32'(busy_o), 1);
      if (ld && wb) begin
        chk("R6 wb_en", 32'(wb_en_o), 1);
        chk("R6 noacc", 32'(mem_req_o), 0);
        chk("R5 wb_val", wb_val_o, wv);
        @(negedge clk_i);
      end
      for (int r = 0; r < 16; r++) begin
        if (l[r]) begin
          chk("R1 req", 32'(mem_req_o), 1);
          chk("R1 idx", 32'(reg_idx_o), r);
          chk("R1 we", 32'(mem_we_o), 32'(!ld));
          chk(first ? "R2 addr" : "R3 addr", mem_addr_o, a);
          chk("R4 seq", 32'(mem_seq_o), 32'(!first));
          chk("R8 ubank", 32'(user_bank_o), 32'(ub));
          chk("R6 nowb", 32'(wb_en_o), 0);
          a = a + 32'd4;
          first = 1'b0;
          @(negedge clk_i);
        end
      end
      chk("R1 end", 32'(mem_req_o), 0);
      if (ld) begin
        chk("R10 idle", 32'(idle_o), 1);
        chk("R9 restore", 32'(psr_restore_o), 32'(rs));
        chk("R6 no_late_wb", 32'(wb_en_o), 0);
      end else begin
        chk("R7 fnseq", 32'(fetch_nseq_o), 1);
        chk("R7 wb_en", 32'(wb_en_o), 32'(wb));
        if (wb) chk("R5 wb_val", wb_val_o, wv);
        chk("R10 noidle", 32'(idle_o), 0);
      end
      @(negedge clk_i);
      chk("R12 done", 32'(done_o), 1);
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R12 free", 32'(busy_o | done_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    void'($urandom(32'd2024));
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 reset", 32'({busy_o, done_o, mem_req_o, wb_en_o, idle_o}), 0);
    // directed corners
    run_op(32'h1000, 16'h0000, 1, 1, 0, 1, 0, 5'h13, 0);   // R11 empty
    run_op(32'h1000, 16'hFFFF, 1, 1, 0, 1, 1, 5'h13, 0);   // R9 restore
    run_op(32'h1000, 16'hFFFF, 1, 1, 0, 1, 1, 5'h10, 0);   // R9 user blocked
    run_op(32'h1000, 16'h8001, 1, 0, 1, 1, 1, 5'h1F, 0);   // R9 system blocked
    run_op(32'h0000, 16'h00F0, 0, 0, 1, 1, 1, 5'h12, 0);   // R2 wrap, R8
    run_op(32'h2000, 16'h0400, 0, 0, 0, 0, 0, 5'h13, 0);   // single entry
    run_op(32'h3000, 16'h7FFF, 1, 1, 1, 0, 1, 5'h11, 0);   // R8 load w/o bit15
    run_op(32'h4000, 16'h0A05, 0, 1, 1, 1, 0, 5'h13, 1);   // R12 inputs ignored
    run_op(32'h5000, 16'h0000, 0, 0, 0, 1, 1, 5'h13, 0);   // R11 empty store
    for (int i = 0; i < 60; i++) begin
      logic [31:0] rb = $urandom & 32'hFFFF_FFFC;
      logic [15:0] rl = 16'($urandom);
      logic [4:0]  rm = modes[$urandom_range(0, 6)];
      if (i % 7 == 3) rl = '0;
      run_op(rb, rl, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), rm, (i % 9 == 5));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule